// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a virtual address into a physical address through a one-level page table that it keeps in its own registers. The virtual address is split into a page number (upper bits) and a word displacement (the low 10 bits, since a page and a frame each hold 1K words). The page number selects a table entry. That entry carries a resident flag, a two-bit permission code and a frame number. When the entry is resident and its permission code allows the requested kind of access, the block returns the frame number joined to the unchanged displacement. Otherwise it reports either a page fault or a protection fault, and never both.

Software loads the table through a write port that takes an index, an entry and a strobe. A translation request is a single cycle with `req_valid` high. The block accepts a request on every cycle. Its answer appears one clock later and lasts one cycle. The virtual space is larger than the physical one: by default there are 64 pages and 32 frames.

The control is a four-state machine whose state holds the outcome of the most recently accepted request:
- `ST_IDLE`: no response this cycle.
- `ST_MAPPED`: a translation succeeded.
- `ST_PAGE_FLT`: the entry was not resident.
- `ST_PROT_FLT`: the permission check failed.

A cycle with `req_valid` high moves the machine from any state into the outcome state for that request. A cycle without a request returns it to `ST_IDLE`.

Top module: `mmu_xlate_unit`

## Requirements
- R1: After reset, `resp_valid`, both fault outputs and `resp_paddr` are 0, and every table entry is non-resident, so any request made before the table is written ends in a page fault.
- R2: A request sampled with `req_valid` high at a clock edge produces `resp_valid` high for exactly the following cycle. With `req_valid` low, `resp_valid` is low one cycle later.
- R3: On success, `resp_paddr` equals the entry's frame number concatenated above the 10 displacement bits of `req_vaddr`. The displacement passes through unchanged and no addition is applied.
- R4: The table entry layout is bit 7 = resident, bits 6:5 = permission code and bits 4:0 = frame number. When the resident bit is 0, the response shows `resp_page_fault`=1, `resp_prot_fault`=0 and `resp_paddr`=0.
- R5: The access kind is encoded as 00 read, 01 write and 10 fetch. The permission code is encoded as 00 read-only, 01 read/write and 10 execute-only. On a resident entry, a read is allowed under 00 and 01, a write only under 01, and a fetch only under 10.
- R6: A resident entry whose permission code forbids the access gives `resp_prot_fault`=1, `resp_page_fault`=0 and `resp_paddr`=0.
- R7: Permission code 11 faults for every access kind, and access kind 11 faults under every permission code. Both cases raise a protection fault on a resident entry.
- R8: When the entry is non-resident and its permission code would also forbid the access, only the page fault is reported.
- R9: A table write is visible to a request made in the next cycle. A request in the same cycle as a write to its page sees the previous entry.
- R10: Requests on consecutive cycles each receive their own response on consecutive cycles, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address (page number, then displacement) |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| pt_we | input | 1 | Page-table write strobe |
| pt_idx | input | 6 | Page-table entry index |
| pt_entry | input | 8 | Entry value {resident, permission[1:0], frame[4:0]} |
| resp_valid | output | 1 | Response present |
| resp_paddr | output | 15 | Physical address, 0 on a fault |
| resp_page_fault | output | 1 | Page not resident |
| resp_prot_fault | output | 1 | Access not permitted |

## Verification
On every cycle, the in-line assertions check four things:
- the response appears exactly one cycle after each request and at no other time;
- at most one fault flag is raised;
- a faulting response carries a zero address, and a successful one carries the request's displacement;
- a table write lands in the addressed entry.

Only the bench's scenarios can show that the frame number is correct for each page and that the full permission matrix, including the reserved codes, is decoded as specified. The same holds for the page-fault priority, and for the old-versus-new entry ordering around a write to the page being translated.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } acc_kind_t;

    typedef enum logic [1:0] {
        PERM_RO   = 2'b00,
        PERM_RW   = 2'b01,
        PERM_XO   = 2'b10,
        PERM_RSVD = 2'b11
    } perm_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_MAPPED   = 2'b01,
        ST_PAGE_FLT = 2'b10,
        ST_PROT_FLT = 2'b11
    } xl_state_t;

endpackage

// File: rtl/mmu_pt_store.sv
module mmu_pt_store #(
    parameter int VPN_W = 6,
    parameter int ENT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [VPN_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_data
);
    localparam int DEPTH = 1 << VPN_W;

    logic [ENT_W-1:0] table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                table_q[i] <= '0;
            end
        end else if (wr_en) begin
            table_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = table_q[rd_idx];

    // R9
    pt_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (table_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
    import mmu_xlate_pkg::*;
(
    input  logic [1:0] kind,
    input  logic [1:0] perm,
    output logic       allowed
);
    always_comb begin
        allowed = 1'b0;
        unique case (kind)
            KIND_READ:  allowed = (perm == PERM_RO) || (perm == PERM_RW);
            KIND_WRITE: allowed = (perm == PERM_RW);
            KIND_FETCH: allowed = (perm == PERM_XO);
            KIND_RSVD:  allowed = 1'b0;
        endcase
    end

    // R7
    rsvd_never_allowed_chk: assert final (
        !((perm == PERM_RSVD || kind == KIND_RSVD) && allowed));

endmodule

// File: rtl/mmu_xlate_unit.sv
module mmu_xlate_unit
    import mmu_xlate_pkg::*;
#(
    parameter int VPN_W = 6,
    parameter int PFN_W = 5,
    parameter int OFF_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    input  logic [1:0]             req_kind,
    input  logic                   pt_we,
    input  logic [VPN_W-1:0]       pt_idx,
    input  logic [PFN_W+2:0]       pt_entry,
    output logic                   resp_valid,
    output logic [PFN_W+OFF_W-1:0] resp_paddr,
    output logic                   resp_page_fault,
    output logic                   resp_prot_fault
);
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int ENT_W = PFN_W + 3;
    localparam int RES_B = ENT_W - 1;

    xl_state_t          state_q, state_d;
    logic [PA_W-1:0]    paddr_q, paddr_d;
    logic [ENT_W-1:0]   pte;
    logic [VPN_W-1:0]   vpn;
    logic [OFF_W-1:0]   disp;
    logic               pte_resident;
    logic [1:0]         pte_perm;
    logic [PFN_W-1:0]   pte_frame;
    logic               access_ok;

    assign vpn  = req_vaddr[VA_W-1:OFF_W];
    assign disp = req_vaddr[OFF_W-1:0];

    mmu_pt_store #(.VPN_W(VPN_W), .ENT_W(ENT_W)) pt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pt_we),
        .wr_idx  (pt_idx),
        .wr_data (pt_entry),
        .rd_idx  (vpn),
        .rd_data (pte)
    );

    assign pte_resident = pte[RES_B];
    assign pte_perm     = pte[RES_B-1:RES_B-2];
    assign pte_frame    = pte[PFN_W-1:0];

    mmu_perm_check perm_i (
        .kind    (req_kind),
        .perm    (pte_perm),
        .allowed (access_ok)
    );

    // Next-state: the state names the outcome of the accepted request.
    always_comb begin
        state_d = ST_IDLE;
        paddr_d = '0;
        if (req_valid) begin
            if (!pte_resident) begin
                state_d = ST_PAGE_FLT;
            end else if (!access_ok) begin
                state_d = ST_PROT_FLT;
            end else begin
                state_d = ST_MAPPED;
                paddr_d = {pte_frame, disp};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            paddr_q <= paddr_d;
        end
    end

    always_comb begin
        resp_valid      = 1'b0;
        resp_page_fault = 1'b0;
        resp_prot_fault = 1'b0;
        resp_paddr      = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MAPPED: begin
                resp_valid = 1'b1;
                resp_paddr = paddr_q;
            end
            ST_PAGE_FLT: begin
                resp_valid      = 1'b1;
                resp_page_fault = 1'b1;
            end
            ST_PROT_FLT: begin
                resp_valid      = 1'b1;
                resp_prot_fault = 1'b1;
            end
        endcase
    end

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R8
    single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_page_fault && resp_prot_fault));

    // R4
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_page_fault || resp_prot_fault) |-> (resp_paddr == '0));

    // R3
    disp_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (resp_page_fault || resp_prot_fault ||
                       resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

endmodule

// File: tb/mmu_xlate_unit_tb_top.sv
module mmu_xlate_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        pt_we;
    logic [5:0]  pt_idx;
    logic [7:0]  pt_entry;
    logic        resp_valid;
    logic [14:0] resp_paddr;
    logic        resp_page_fault;
    logic        resp_prot_fault;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [64];

    always #5 clk = ~clk;

    mmu_xlate_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .pt_we(pt_we), .pt_idx(pt_idx), .pt_entry(pt_entry),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_page_fault(resp_page_fault), .resp_prot_fault(resp_prot_fault)
    );

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual valid/pf/prf/pa=%h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] expect_of(input logic [7:0] e, input logic [1:0] k,
                                              input logic [9:0] off);
        logic ok;
        ok = (k == 2'd0 && (e[6:5] == 2'd0 || e[6:5] == 2'd1)) ||
             (k == 2'd1 && e[6:5] == 2'd1) ||
             (k == 2'd2 && e[6:5] == 2'd2);
        if (!e[7])   return {1'b1, 1'b1, 1'b0, 15'd0};
        else if (!ok) return {1'b1, 1'b0, 1'b1, 15'd0};
        else          return {1'b1, 1'b0, 1'b0, 15'(e[4:0] * 1024 + off)};
    endfunction

    function automatic logic [17:0] outs();
        return {resp_valid, resp_page_fault, resp_prot_fault, resp_paddr};
    endfunction

    task automatic write_pte(input int p, input logic [7:0] e);
        @(negedge clk);
        req_valid = 1'b0;
        pt_we = 1'b1; pt_idx = 6'(p); pt_entry = e;
        @(negedge clk);
        pt_we = 1'b0;
        model[p] = e;
    endtask

    // Drives at negedge, samples just after the next posedge (one register).
    task automatic translate(input string tag, input int p, input logic [1:0] k,
                             input logic [9:0] off);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {6'(p), off}; req_kind = k;
        @(posedge clk); #1;
        check(tag, outs(), expect_of(model[p], k, off));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        pt_we = 1'b0; pt_idx = '0; pt_entry = '0;
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", outs(), 18'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: empty table faults everywhere
        translate("R1 empty table", 0, 2'd0, 10'd5);
        translate("R1 empty table", 63, 2'd2, 10'd1023);

        // Load the whole table with computed entries
        for (int p = 0; p < 64; p++)
            write_pte(p, {1'(p % 5 != 0), 2'(p % 4), 5'((p * 7 + 3) % 32)});

        // R2 idle gap: no response after a quiet cycle
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        check("R2 no request", {17'd0, resp_valid}, 18'd0);

        // R3 R4 R5 R6 R7 R8 R10: back-to-back sweep of every page and kind
        for (int p = 0; p < 64; p++)
            for (int k = 0; k < 4; k++)
                translate("R3-sweep R5 R6 R7 R8 R10", p, 2'(k), 10'((p * 37 + k * 251) % 1024));

        // R3 displacement boundaries on a read/write page (page 1: rights 01)
        translate("R3 disp 0", 1, 2'd1, 10'd0);
        translate("R3 disp max", 1, 2'd0, 10'd1023);

        // R8: non-resident with reserved rights and reserved kind
        write_pte(10, 8'b0_11_10101);
        translate("R8 priority", 10, 2'd3, 10'd9);
        // R7: resident, reserved rights
        write_pte(11, 8'b1_11_00001);
        translate("R7 rsvd perm", 11, 2'd0, 10'd9);

        // R9: same-cycle write sees old, next cycle sees new
        write_pte(12, 8'b1_00_00100);
        @(negedge clk);
        pt_we = 1'b1; pt_idx = 6'd12; pt_entry = 8'b1_10_11111;
        req_valid = 1'b1; req_vaddr = {6'd12, 10'd77}; req_kind = 2'd2;
        @(posedge clk); #1;
        check("R9 old entry", outs(), expect_of(8'b1_00_00100, 2'd2, 10'd77));
        @(negedge clk);
        pt_we = 1'b0;
        model[12] = 8'b1_10_11111;
        @(posedge clk); #1;
        check("R9 new entry", outs(), expect_of(model[12], 2'd2, 10'd77));

        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        check("R2 drop", {17'd0, resp_valid}, 18'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule